// File: doc/BRIEF.md
# Shadow Configuration Reload and Event Interrupt Unit

This unit sits between a register write port and the display pipeline. Software writes configuration words into a bank of shadow registers. The pipeline only sees a separate active copy. The shadow bank is copied into the active bank in one cycle, and only when software asks for it. A request can take effect at once, or it can wait for the next vertical-blanking strobe from the timing generator, so that a frame is never shown with half of its settings changed.

The same unit collects four events into a sticky status register:
- a line event,
- a FIFO underrun,
- a transfer error,
- completion of a reload.

An enable register selects which flags drive the single interrupt line. Software acknowledges flags by writing ones to a clear register.

Register addresses are word indices on the write port:
- Shadow words occupy `0` to `NUM_CFG-1`.
- The reload control register is at `NUM_CFG`.
- The interrupt enable register is at `NUM_CFG+1`.
- The interrupt clear register is at `NUM_CFG+2`.
- Every other address is unmapped.

The write port uses valid/ready. Ready is always high, so a write is taken in any cycle where valid is high, and there is no back-pressure.

Top module: `shadow_reload_irq`

## Requirements
- R1: A write to a shadow word does not change `active_cfg` until a reload transfer happens. Shadow word i appears in `active_cfg[i*DATA_W +: DATA_W]`.
- R2: Writing the reload register with bit 0 set requests an immediate transfer. `reload_pending[0]` reads 1 in the cycle after the write. In the following cycle all shadow words appear on `active_cfg` and the bit has cleared itself.
- R3: Writing the reload register with bit 1 set requests a transfer at vertical blanking. `reload_pending[1]` stays set, and `active_cfg` is unchanged, until a cycle with `vblank` high. That cycle performs the transfer and clears the bit.
- R4: When both request bits are pending, the immediate request performs the transfer. Both bits clear together, and a later `vblank` causes no further transfer.
- R5: `evt_status` bit 0 is set by `line_evt`, bit 1 by `fifo_underrun`, bit 2 by `bus_err`, and bit 3 by a completed transfer. Each flag is sticky, and the flag is visible in the cycle after its event.
- R6: A write to the clear register clears each `evt_status` bit whose data bit is 1. Bits written as 0 are unaffected.
- R7: When a flag is set by an event and cleared by a write in the same cycle, it remains set.
- R8: The interrupt enable register uses the same bit positions as `evt_status`. `irq` is high exactly when some status bit and its enable bit are both 1.
- R9: After reset, `active_cfg`, `reload_pending`, `evt_status` and `irq` are all zero, and `cfg_wready` is 1.
- R10: A write to an unmapped address changes no shadow word, no active word, no request bit and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wvalid | input | 1 | Write request valid |
| cfg_wready | output | 1 | Write accepted; always 1 |
| cfg_waddr | input | ADDR_W | Word address of the write |
| cfg_wdata | input | DATA_W | Write data |
| vblank | input | 1 | Vertical-blanking strobe from the timing generator |
| line_evt | input | 1 | Line event pulse |
| fifo_underrun | input | 1 | FIFO underrun pulse |
| bus_err | input | 1 | Transfer error pulse |
| active_cfg | output | NUM_CFG*DATA_W | Active configuration words, word 0 in the low bits |
| reload_pending | output | 2 | Outstanding requests: bit 0 immediate, bit 1 vertical blanking |
| evt_status | output | 4 | Sticky event flags |
| irq | output | 1 | Interrupt line |

## Verification
The bench targets the following ordering cases, and each one shows up at the ports if the design gets it wrong:
- **Blanking request held across idle cycles.** A design that moved the shadow bank on request instead of on `vblank` would expose the new word early.
- **Immediate request on top of a pending blanking request.** A design that failed to drop the blanking request would copy a later shadow write at the next strobe.
- **Event and clear in the same cycle.** If the clear won, an event would be lost.
- **Clear mask covering bits that are not set.** A clear that acts on zero bits would disturb neighbouring flags.
- **Write to an unmapped address.** If it aliased onto a shadow word, the next reload would reveal it.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int EVT_N = 4;
  localparam int EVT_LINE   = 0;
  localparam int EVT_UNDER  = 1;
  localparam int EVT_BUSERR = 2;
  localparam int EVT_RELOAD = 3;
  localparam int REQ_IMM = 0;
  localparam int REQ_VB  = 1;

  typedef enum logic [1:0] {
    SEL_SHADOW = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_IER    = 2'd2,
    SEL_ICR    = 2'd3
  } wsel_e;
endpackage

// File: rtl/srl_shadow_bank.sv
module srl_shadow_bank #(
  parameter int NUM_CFG = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      xfer,
  output logic [NUM_CFG*DATA_W-1:0] active
);
  for (genvar i = 0; i < NUM_CFG; i++) begin : g_word
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] active_q;
    logic              hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (hit)  shadow_q <= wr_data;
        if (xfer) active_q <= shadow_q;
      end
    end
    assign active[i*DATA_W +: DATA_W] = active_q;
  end
endmodule

// File: rtl/srl_reload_ctrl.sv
module srl_reload_ctrl
  import srl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_wr,
  input  logic [1:0] req_bits,
  input  logic       vblank,
  output logic       xfer,
  output logic [1:0] pending
);
  logic [1:0] pend_q;
  logic [1:0] pend_d;

  assign xfer = pend_q[REQ_IMM] | (pend_q[REQ_VB] & vblank);

  always_comb begin
    pend_d = xfer ? 2'b00 : pend_q;
    if (req_wr) pend_d = pend_d | req_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 2'b00;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;
endmodule

// File: rtl/srl_irq_unit.sv
module srl_irq_unit
  import srl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_set,
  input  logic             ier_wr,
  input  logic             icr_wr,
  input  logic [EVT_N-1:0] wr_bits,
  output logic [EVT_N-1:0] status,
  output logic             irq
);
  logic [EVT_N-1:0] status_q;
  logic [EVT_N-1:0] ier_q;
  logic [EVT_N-1:0] clr_mask;

  assign clr_mask = icr_wr ? wr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      ier_q    <= '0;
    end else begin
      status_q <= (status_q & ~clr_mask) | evt_set;
      if (ier_wr) ier_q <= wr_bits;
    end
  end

  assign status = status_q;
  assign irq    = |(status_q & ier_q);
endmodule

// File: rtl/shadow_reload_irq.sv
module shadow_reload_irq
  import srl_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = $clog2(NUM_CFG + 3)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wvalid,
  output logic                      cfg_wready,
  input  logic [ADDR_W-1:0]         cfg_waddr,
  input  logic [DATA_W-1:0]         cfg_wdata,
  input  logic                      vblank,
  input  logic                      line_evt,
  input  logic                      fifo_underrun,
  input  logic                      bus_err,
  output logic [NUM_CFG*DATA_W-1:0] active_cfg,
  output logic [1:0]                reload_pending,
  output logic [3:0]                evt_status,
  output logic                      irq
);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(NUM_CFG);
  localparam logic [ADDR_W-1:0] A_IER    = ADDR_W'(NUM_CFG + 1);
  localparam logic [ADDR_W-1:0] A_ICR    = ADDR_W'(NUM_CFG + 2);

  logic             wr_fire;
  logic             xfer;
  logic             sel_valid;
  wsel_e            sel;
  logic [EVT_N-1:0] evt_set;

  assign cfg_wready = 1'b1;
  assign wr_fire    = cfg_wvalid && cfg_wready;

  always_comb begin
    sel       = SEL_SHADOW;
    sel_valid = 1'b0;
    if (cfg_waddr == A_RELOAD) begin
      sel = SEL_RELOAD; sel_valid = 1'b1;
    end else if (cfg_waddr == A_IER) begin
      sel = SEL_IER; sel_valid = 1'b1;
    end else if (cfg_waddr == A_ICR) begin
      sel = SEL_ICR; sel_valid = 1'b1;
    end
  end

  srl_shadow_bank #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire && !sel_valid),
    .wr_addr (cfg_waddr),
    .wr_data (cfg_wdata),
    .xfer    (xfer),
    .active  (active_cfg)
  );

  srl_reload_ctrl u_reload (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_wr   (wr_fire && sel_valid && sel == SEL_RELOAD),
    .req_bits (cfg_wdata[1:0]),
    .vblank   (vblank),
    .xfer     (xfer),
    .pending  (reload_pending)
  );

  always_comb begin
    evt_set             = '0;
    evt_set[EVT_LINE]   = line_evt;
    evt_set[EVT_UNDER]  = fifo_underrun;
    evt_set[EVT_BUSERR] = bus_err;
    evt_set[EVT_RELOAD] = xfer;
  end

  srl_irq_unit u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_set (evt_set),
    .ier_wr  (wr_fire && sel_valid && sel == SEL_IER),
    .icr_wr  (wr_fire && sel_valid && sel == SEL_ICR),
    .wr_bits (cfg_wdata[EVT_N-1:0]),
    .status  (evt_status),
    .irq     (irq)
  );
endmodule

// File: rtl/shadow_reload_irq_chk.sv
module shadow_reload_irq_chk #(
  parameter int NUM_CFG = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_wvalid,
  input logic [ADDR_W-1:0]         cfg_waddr,
  input logic [DATA_W-1:0]         cfg_wdata,
  input logic                      vblank,
  input logic                      fifo_underrun,
  input logic [NUM_CFG*DATA_W-1:0] active_cfg,
  input logic [1:0]                reload_pending,
  input logic [3:0]                evt_status,
  input logic                      irq
);
  logic rld_wr;
  assign rld_wr = cfg_wvalid && (cfg_waddr == ADDR_W'(NUM_CFG));

  // R1: with no request outstanding the active bank cannot move
  a_r1_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pending == 2'b00 |=> $stable(active_cfg));

  // R2: the immediate request clears itself unless re-requested
  a_r2_imm_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pending[0] && !(rld_wr && cfg_wdata[0]) |=> !reload_pending[0]);

  // R2, R5: a performed immediate transfer raises the reload flag
  a_r2_imm_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pending[0] |=> evt_status[3]);

  // R3: a blanking request waits for the strobe
  a_r3_vb_wait: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pending == 2'b10 && !vblank |=> reload_pending[1] && $stable(active_cfg));

  // R3: the strobe consumes the blanking request
  a_r3_vb_consume: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pending == 2'b10 && vblank && !(rld_wr && cfg_wdata[1]) |=> !reload_pending[1]);

  // R4: both pending -> both gone after the transfer
  a_r4_imm_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pending == 2'b11 && !rld_wr |=> reload_pending == 2'b00);

  // R5: the underrun flag rises only after an underrun pulse
  a_r5_underrun_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_status[1]) |-> $past(fifo_underrun));

  // R7: an event always leaves its flag set, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_underrun |=> evt_status[1]);

  // R8: no flag, no interrupt
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    evt_status == 4'b0000 |-> !irq);
endmodule

bind shadow_reload_irq shadow_reload_irq_chk #(
  .NUM_CFG(NUM_CFG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_wvalid     (cfg_wvalid),
  .cfg_waddr      (cfg_waddr),
  .cfg_wdata      (cfg_wdata),
  .vblank         (vblank),
  .fifo_underrun  (fifo_underrun),
  .active_cfg     (active_cfg),
  .reload_pending (reload_pending),
  .evt_status     (evt_status),
  .irq            (irq)
);

// File: tb/tb_shadow_reload_irq.sv
`timescale 1ns/1ps
module tb_shadow_reload_irq;
  localparam int NUM_CFG = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam logic [ADDR_W-1:0] A_RLD  = 3'd4;
  localparam logic [ADDR_W-1:0] A_IER  = 3'd5;
  localparam logic [ADDR_W-1:0] A_ICR  = 3'd6;
  localparam logic [ADDR_W-1:0] A_NONE = 3'd7;

  // {events err/und/line, clear mask, enable, expected status, expected irq}
  localparam logic [15:0] TBL [8] = '{
    {3'b001, 4'b0000, 4'b0000, 4'b0001, 1'b0},
    {3'b000, 4'b0000, 4'b0001, 4'b0001, 1'b1},
    {3'b010, 4'b0001, 4'b0010, 4'b0010, 1'b1},
    {3'b100, 4'b0010, 4'b0010, 4'b0100, 1'b0},
    {3'b100, 4'b0100, 4'b0100, 4'b0100, 1'b1},
    {3'b000, 4'b1011, 4'b0100, 4'b0100, 1'b1},
    {3'b011, 4'b0100, 4'b1000, 4'b0011, 1'b0},
    {3'b000, 4'b1111, 4'b1111, 4'b0000, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wvalid = 1'b0;
  logic cfg_wready;
  logic [ADDR_W-1:0] cfg_waddr = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic vblank = 1'b0, line_evt = 1'b0, fifo_underrun = 1'b0, bus_err = 1'b0;
  logic [NUM_CFG*DATA_W-1:0] active_cfg;
  logic [1:0] reload_pending;
  logic [3:0] evt_status;
  logic irq;

  logic [DATA_W-1:0] exp_sh [NUM_CFG];
  logic [DATA_W-1:0] exp_act [NUM_CFG];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shadow_reload_irq #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W)) dut (.*);

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    cfg_wvalid = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wvalid = 1'b0;
  endtask

  function automatic logic [NUM_CFG*DATA_W-1:0] exp_flat();
    logic [NUM_CFG*DATA_W-1:0] f;
    for (int i = 0; i < NUM_CFG; i++) f[i*DATA_W +: DATA_W] = exp_act[i];
    return f;
  endfunction

  task automatic do_xfer();
    for (int i = 0; i < NUM_CFG; i++) exp_act[i] = exp_sh[i];
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_CFG; i++) begin exp_sh[i] = '0; exp_act[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 active", active_cfg, '0);
    check("R9 pending", reload_pending, 2'b00);
    check("R9 status", evt_status, 4'b0);
    check("R9 irq/ready", {irq, cfg_wready}, 2'b01);

    // R1 shadow writes stay hidden
    wr(3'd0, 32'hA0A0_0001); exp_sh[0] = 32'hA0A0_0001;
    wr(3'd1, 32'hB1B1_0002); exp_sh[1] = 32'hB1B1_0002;
    @(negedge clk);
    check("R1 active unchanged", active_cfg, exp_flat());

    // R2 immediate reload
    wr(A_RLD, 32'h1);
    check("R2 pending set", reload_pending, 2'b01);
    check("R2 not yet moved", active_cfg, exp_flat());
    @(negedge clk); do_xfer();
    check("R2 active copied", active_cfg, exp_flat());
    check("R2 self clear", reload_pending, 2'b00);
    check("R5 reload flag", evt_status, 4'b1000);
    wr(A_ICR, 32'h8);
    check("R6 flag cleared", evt_status, 4'b0000);

    // R3 blanking reload
    wr(3'd2, 32'hC2C2_0003); exp_sh[2] = 32'hC2C2_0003;
    wr(A_RLD, 32'h2);
    repeat (3) @(negedge clk);
    check("R3 waits pending", reload_pending, 2'b10);
    check("R3 waits active", active_cfg, exp_flat());
    vblank = 1'b1; @(negedge clk); vblank = 1'b0; do_xfer();
    check("R3 active at vblank", active_cfg, exp_flat());
    check("R3 pending cleared", reload_pending, 2'b00);
    check("R5 reload flag vb", evt_status[3], 1'b1);
    wr(A_ICR, 32'hF);

    // R4 immediate over pending blanking request
    wr(3'd3, 32'hD3D3_0004); exp_sh[3] = 32'hD3D3_0004;
    wr(A_RLD, 32'h2);
    wr(A_RLD, 32'h1);
    check("R4 both pending", reload_pending, 2'b11);
    @(negedge clk); do_xfer();
    check("R4 transfer", active_cfg, exp_flat());
    check("R4 both cleared", reload_pending, 2'b00);
    wr(3'd0, 32'hE0E0_0005); exp_sh[0] = 32'hE0E0_0005;
    vblank = 1'b1; @(negedge clk); vblank = 1'b0;
    @(negedge clk);
    check("R4 later vblank no transfer", active_cfg, exp_flat());
    wr(A_ICR, 32'hF);

    // R10 unmapped write
    wr(A_NONE, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R10 active", active_cfg, exp_flat());
    check("R10 pending/status/irq", {reload_pending, evt_status, irq}, 7'b0);
    wr(A_RLD, 32'h1);
    @(negedge clk); do_xfer();
    check("R10 shadow intact", active_cfg, exp_flat());
    wr(A_ICR, 32'hF);

    // R5..R8 vector table
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      v = TBL[i];
      wr(A_IER, {28'b0, v[8:5]});
      @(negedge clk);
      {bus_err, fifo_underrun, line_evt} = v[15:13];
      cfg_wvalid = (v[12:9] != 4'b0); cfg_waddr = A_ICR; cfg_wdata = {28'b0, v[12:9]};
      @(negedge clk);
      {bus_err, fifo_underrun, line_evt} = 3'b000; cfg_wvalid = 1'b0;
      check($sformatf("R5 R6 R7 status row %0d", i), evt_status, v[4:1]);
      check($sformatf("R8 irq row %0d", i), irq, v[0]);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule